// File: doc/BRIEF.md
# Shared-Buffer Multi-Queue Word FIFO Manager

This block manages a set of hardware word queues whose storage is carved out of one shared buffer memory. Each queue has its own configuration word holding a base address in the buffer, a length code, two watermark codes and an interrupt condition selector. Software, or any bus master, pushes a word by writing to the queue's four-word access window and pops a word by reading from it. Read and write pointers wrap inside each queue's region.

The block derives four status conditions per queue: empty, nearly empty, nearly full and full. Status is reported in full for the lower half of the queues. The upper half reports only nearly-empty and full, as single bits. The lower half also records sticky underflow and overflow events. Each queue can raise an interrupt from a chosen condition or its negation. Pending interrupts are latched on a rising edge of that condition, masked by a per-queue enable, and merged onto one interrupt output.

All addresses are word addresses. Read data appears on `bus_rdata` one clock after the cycle in which `bus_re` is high. A cycle with both `bus_we` and `bus_re` high counts as a write.

Top module: `qm`

## Requirements
- R1: A write to word address 4*q..4*q+3 (q = 0..63, any of the four offsets) pushes the data onto queue q. A read there pops the oldest word, so words come out in push order. This holds across the wrap of the pointers at the queue length.
- R2: The configuration word of queue q is at address 0x200+q and reads back as written. Its fields are: bits 10:0 base, bits 12:11 length code (length = 16 << code), bits 15:13 nearly-empty code, bits 18:16 nearly-full code, bits 21:19 interrupt source. A write to it empties the queue. After reset, queue q has base 32*q, length code 1 and all other fields 0.
- R3: Status word 0x100+w (w = 0..3) holds queues 8w..8w+7, with queue 8w+j in bits 4j+3:4j. Within each nibble, bit0 is empty, bit1 nearly empty, bit2 nearly full and bit3 full.
- R4: Watermark codes 0..7 select thresholds 0, 1, 2, 4, 8, 16, 32 and 64. A queue is nearly empty when its count is at or below the nearly-empty threshold. It is nearly full when its free space is at or below the nearly-full threshold.
- R5: Word 0x106 holds the nearly-empty flag, and word 0x107 the full flag, of queue 32+i in bit i.
- R6: A push to a full queue is dropped. For queues 0..31 it sets the overflow bit. Queues 32..63 keep no sticky flags.
- R7: A pop from an empty queue returns 0 and leaves the queue unchanged. For queues 0..31 it sets the underflow bit.
- R8: Sticky word 0x104+w holds queue 16w+k with underflow in bit 2k and overflow in bit 2k+1. A flag stays set until a 1 is written to its bit.
- R9: Interrupt source codes 0..3 select empty, nearly empty, nearly full and full. Codes 4..7 select the negation of the same conditions in the same order.
- R10: The pending bit of queue q (bit q mod 32 of word 0x10A + q/32) is set on a rising edge of the selected condition while the enable bit (same position in 0x108/0x109) is 1. Writing 1 to a pending bit clears it.
- R11: `irq` is high exactly when some queue has both its pending bit and its enable bit set.
- R12: Register read data is valid one cycle after the read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_re |
| irq | output | 1 | Merged interrupt request |

## Verification
A wrong count or pointer in one queue shows up in that queue's status nibble or upper-half flag bit on the next status read. It also shows up as wrong data, or data out of order, on the first pop that reaches the damaged slot. A missed or spurious condition edge shows up at `irq` two cycles after the push or pop that caused it, so the bench waits a few idle cycles before sampling. Sticky and pending bits are read back after every event that should or should not touch them. This exposes both a bit that failed to set and a bit that was cleared without a write of 1.

// File: rtl/qm_pkg.sv
package qm_pkg;
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_MEM  = 2'd1,
        RSEL_REG  = 2'd2
    } rsel_e;

    // Watermark code to entry threshold: 0, then powers of two from 1 to 64.
    function automatic logic [7:0] wm_thresh(input logic [2:0] code);
        return (code == 3'd0) ? 8'd0 : 8'(1 << (code - 3'd1));
    endfunction
endpackage

// File: rtl/qm_buffer.sv
module qm_buffer #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/qm_flags.sv
module qm_flags #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned MIN_LEN = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       size,
    input  logic [2:0]       ne_code,
    input  logic [2:0]       nf_code,
    input  logic [2:0]       src,
    output logic [3:0]       status,
    output logic             cond
);
    import qm_pkg::*;

    logic [CNT_W-1:0] len, free, thr_ne, thr_nf;

    always_comb begin
        len       = CNT_W'(MIN_LEN) << size;
        free      = len - cnt;
        thr_ne    = CNT_W'(wm_thresh(ne_code));
        thr_nf    = CNT_W'(wm_thresh(nf_code));
        status[0] = (cnt == '0);
        status[1] = (cnt <= thr_ne);
        status[2] = (free <= thr_nf);
        status[3] = (cnt == len);
        cond      = src[2] ^ status[src[1:0]];
    end
endmodule

// File: rtl/qm.sv
module qm #(
    parameter int unsigned NQ      = 64,
    parameter int unsigned DW      = 32,
    parameter int unsigned AW      = 12,
    parameter int unsigned BUF_AW  = 11,
    parameter int unsigned PTR_W   = 7,
    parameter int unsigned MIN_LEN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    import qm_pkg::*;

    localparam int unsigned CNT_W     = PTR_W + 1;
    localparam int unsigned QW        = $clog2(NQ);
    localparam int unsigned LOW       = NQ / 2;
    localparam int unsigned WIN_SPAN  = NQ * 4;
    localparam int unsigned ST_PER_W  = DW / 4;
    localparam int unsigned ST_WORDS  = LOW / ST_PER_W;
    localparam int unsigned FL_WORDS  = (2 * LOW) / DW;
    localparam int unsigned EN_WORDS  = NQ / DW;
    localparam int unsigned STAT_BASE = WIN_SPAN;
    localparam int unsigned FLAG_BASE = STAT_BASE + ST_WORDS;
    localparam int unsigned UNE_ADDR  = FLAG_BASE + FL_WORDS;
    localparam int unsigned UFU_ADDR  = UNE_ADDR + 1;
    localparam int unsigned EN_BASE   = UFU_ADDR + 1;
    localparam int unsigned PEND_BASE = EN_BASE + EN_WORDS;
    localparam int unsigned CFG_BASE  = 2 * WIN_SPAN;
    localparam int unsigned SZ_LSB    = BUF_AW;
    localparam int unsigned NE_LSB    = BUF_AW + 2;
    localparam int unsigned NF_LSB    = BUF_AW + 5;
    localparam int unsigned SRC_LSB   = BUF_AW + 8;
    localparam int unsigned CFG_W     = BUF_AW + 11;
    localparam int unsigned DEF_LEN   = (1 << BUF_AW) / NQ;
    localparam int unsigned DEF_SZ    = $clog2(DEF_LEN / MIN_LEN);

    typedef struct packed {
        logic [NQ-1:0][CFG_W-1:0] cfg;
        logic [NQ-1:0][PTR_W-1:0] rd;
        logic [NQ-1:0][PTR_W-1:0] wr;
        logic [NQ-1:0][CNT_W-1:0] cnt;
        logic [NQ-1:0]            en;
        logic [NQ-1:0]            pend;
        logic [NQ-1:0]            prev;
        logic [2*LOW-1:0]         sticky;
        rsel_e                    rsel;
        logic [DW-1:0]            rdata;
    } state_t;

    state_t st_d, st_q, st_rst;

    logic [NQ-1:0][3:0] stat;
    logic [NQ-1:0]      cond;

    logic              mem_we, mem_re;
    logic [BUF_AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0]     mem_rdata;

    logic              win_hit, cfg_hit;
    logic [QW-1:0]     qsel;
    logic [BUF_AW-1:0] qbase;
    logic [PTR_W-1:0]  qmask;
    logic [CNT_W-1:0]  qlen;

    for (genvar q = 0; q < NQ; q++) begin : g_flags
        qm_flags #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_flags (
            .cnt     (st_q.cnt[q]),
            .size    (st_q.cfg[q][SZ_LSB +: 2]),
            .ne_code (st_q.cfg[q][NE_LSB +: 3]),
            .nf_code (st_q.cfg[q][NF_LSB +: 3]),
            .src     (st_q.cfg[q][SRC_LSB +: 3]),
            .status  (stat[q]),
            .cond    (cond[q])
        );
    end

    qm_buffer #(.DW(DW), .AW(BUF_AW)) u_buffer (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (bus_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    always_comb begin
        st_rst = '0;
        for (int q = 0; q < NQ; q++) begin
            st_rst.cfg[q][BUF_AW-1:0]    = BUF_AW'(q * DEF_LEN);
            st_rst.cfg[q][SZ_LSB +: 2]   = 2'(DEF_SZ);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.rsel = RSEL_NONE;
        st_d.rdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_waddr = '0;
        mem_raddr = '0;
        win_hit   = (bus_addr < AW'(WIN_SPAN));
        cfg_hit   = (bus_addr >= AW'(CFG_BASE)) && (bus_addr < AW'(CFG_BASE + NQ));
        qsel      = win_hit ? bus_addr[QW+1:2] : bus_addr[QW-1:0];
        qbase     = st_q.cfg[qsel][BUF_AW-1:0];
        qlen      = CNT_W'(MIN_LEN) << st_q.cfg[qsel][SZ_LSB +: 2];
        qmask     = PTR_W'(qlen - 1'b1);

        if (bus_we && win_hit) begin
            if (stat[qsel][3]) begin
                if (qsel < QW'(LOW)) st_d.sticky[{qsel[QW-2:0], 1'b1}] = 1'b1;
            end else begin
                mem_we           = 1'b1;
                mem_waddr        = qbase + BUF_AW'(st_q.wr[qsel]);
                st_d.wr[qsel]    = (st_q.wr[qsel] + 1'b1) & qmask;
                st_d.cnt[qsel]   = st_q.cnt[qsel] + 1'b1;
            end
        end else if (bus_re && win_hit) begin
            if (stat[qsel][0]) begin
                st_d.rsel = RSEL_REG;
                if (qsel < QW'(LOW)) st_d.sticky[{qsel[QW-2:0], 1'b0}] = 1'b1;
            end else begin
                st_d.rsel        = RSEL_MEM;
                mem_re           = 1'b1;
                mem_raddr        = qbase + BUF_AW'(st_q.rd[qsel]);
                st_d.rd[qsel]    = (st_q.rd[qsel] + 1'b1) & qmask;
                st_d.cnt[qsel]   = st_q.cnt[qsel] - 1'b1;
            end
        end else if (bus_we) begin
            for (int w = 0; w < FL_WORDS; w++)
                if (bus_addr == AW'(FLAG_BASE + w)) st_d.sticky[w*DW +: DW] = st_q.sticky[w*DW +: DW] & ~bus_wdata;
            for (int w = 0; w < EN_WORDS; w++) begin
                if (bus_addr == AW'(EN_BASE + w))   st_d.en[w*DW +: DW]   = bus_wdata;
                if (bus_addr == AW'(PEND_BASE + w)) st_d.pend[w*DW +: DW] = st_q.pend[w*DW +: DW] & ~bus_wdata;
            end
            if (cfg_hit) begin
                st_d.cfg[qsel] = bus_wdata[CFG_W-1:0];
                st_d.rd[qsel]  = '0;
                st_d.wr[qsel]  = '0;
                st_d.cnt[qsel] = '0;
            end
        end else if (bus_re) begin
            st_d.rsel = RSEL_REG;
            for (int w = 0; w < ST_WORDS; w++)
                if (bus_addr == AW'(STAT_BASE + w))
                    for (int j = 0; j < ST_PER_W; j++) st_d.rdata[4*j +: 4] = stat[w*ST_PER_W + j];
            for (int w = 0; w < FL_WORDS; w++)
                if (bus_addr == AW'(FLAG_BASE + w)) st_d.rdata = st_q.sticky[w*DW +: DW];
            for (int w = 0; w < EN_WORDS; w++) begin
                if (bus_addr == AW'(EN_BASE + w))   st_d.rdata = st_q.en[w*DW +: DW];
                if (bus_addr == AW'(PEND_BASE + w)) st_d.rdata = st_q.pend[w*DW +: DW];
            end
            for (int q = LOW; q < NQ; q++) begin
                if (bus_addr == AW'(UNE_ADDR)) st_d.rdata[q-LOW] = stat[q][1];
                if (bus_addr == AW'(UFU_ADDR)) st_d.rdata[q-LOW] = stat[q][3];
            end
            if (cfg_hit) st_d.rdata = DW'(st_q.cfg[qsel]);
        end

        // Condition edge detection; a new event wins over a same-cycle clear.
        st_d.pend = st_d.pend | (cond & ~st_q.prev & st_q.en);
        st_d.prev = cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign bus_rdata = (st_q.rsel == RSEL_MEM) ? mem_rdata : st_q.rdata;
    assign irq       = |(st_q.pend & st_q.en);
endmodule

// File: rtl/qm_chk.sv
module qm_chk #(
    parameter int unsigned NQ      = 64,
    parameter int unsigned LOW     = 32,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned CFG_W   = 22,
    parameter int unsigned SZ_LSB  = 11,
    parameter int unsigned MIN_LEN = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_we,
    input logic                      irq,
    input logic [NQ-1:0]             en,
    input logic [NQ-1:0]             pend,
    input logic [2*LOW-1:0]          sticky,
    input logic [NQ-1:0][CNT_W-1:0]  cnt,
    input logic [NQ-1:0][CFG_W-1:0]  cfg
);
    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

    // R10
    pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(en)) == '0);

    // R10
    pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~pend) != '0) |-> $past(bus_we));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sticky) & ~sticky) != '0) |-> $past(bus_we));

    for (genvar q = 0; q < NQ; q++) begin : g_cnt
        // R6
        count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[q] <= (CNT_W'(MIN_LEN) << cfg[q][SZ_LSB +: 2]));
    end
endmodule

bind qm qm_chk #(
    .NQ(NQ), .LOW(LOW), .CNT_W(CNT_W), .CFG_W(CFG_W), .SZ_LSB(SZ_LSB), .MIN_LEN(MIN_LEN)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_we (bus_we),
    .irq    (irq),
    .en     (st_q.en),
    .pend   (st_q.pend),
    .sticky (st_q.sticky),
    .cnt    (st_q.cnt),
    .cfg    (st_q.cfg)
);

// File: tb/test_qm.sv
module test_qm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    qm i_qm (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R11 irq after reset", {31'd0, irq}, 32'd0);
        rd(12'h100, d); check("R3 reset status word 0", d, 32'h33333333);
        rd(12'h103, d); check("R3 reset status word 3", d, 32'h33333333);
        rd(12'h106, d); check("R5 reset upper nearly-empty", d, 32'hFFFFFFFF);
        rd(12'h107, d); check("R5 reset upper full", d, 32'h0);
        rd(12'h104, d); check("R8 reset sticky", d, 32'h0);
        rd(12'h205, d); check("R2 reset config q5", d, 32'h000008A0);
    endtask

    task automatic t_fifo;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) wr(12'(i), 32'hA000_0000 + 32'(i));
        idle(1);
        rd(12'h100, d); check("R3 q0 holding four", d, 32'h33333330);
        for (int i = 0; i < 4; i++) begin
            rd(12'(3 - i), d); check("R1 pop order q0", d, 32'hA000_0000 + 32'(i));
        end
    endtask

    task automatic t_wm;
        logic [31:0] d;
        wr(12'h200, 32'h00034000);
        rd(12'h200, d); check("R2 config readback q0", d, 32'h00034000);
        for (int i = 0; i < 2; i++) wr(12'h000, 32'(i));
        idle(1);
        rd(12'h100, d); check("R4 count 2 nearly empty", d, 32'h33333332);
        wr(12'h000, 32'd2);
        idle(1);
        rd(12'h100, d); check("R4 count 3 not nearly empty", d, 32'h33333330);
        for (int i = 3; i < 12; i++) wr(12'h000, 32'(i));
        idle(1);
        rd(12'h100, d); check("R4 free 4 nearly full", d, 32'h33333334);
        wr(12'h203, 32'h0007FC00);
        for (int i = 0; i < 64; i++) wr(12'h00C, 32'(i));
        idle(1);
        rd(12'h100, d); check("R4 code7 at 64 both marks", d, 32'h33336334);
        wr(12'h00C, 32'd64);
        idle(1);
        rd(12'h100, d); check("R4 code7 at 65 nearly full only", d, 32'h33334334);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        wr(12'h201, 32'h00000100);
        for (int i = 0; i < 16; i++) wr(12'h004 + 12'(i % 4), 32'hB000_0000 + 32'(i));
        wr(12'h005, 32'hDEADBEEF);
        idle(1);
        rd(12'h100, d); check("R3 q1 full nibble", d, 32'h333343C4);
        rd(12'h104, d); check("R6 overflow sticky q1", d, 32'h00000008);
        for (int i = 0; i < 16; i++) begin
            rd(12'h006, d); check("R6 dropped push not stored", d, 32'hB000_0000 + 32'(i));
        end
        rd(12'h004, d); check("R7 empty pop returns zero", d, 32'h0);
        rd(12'h104, d); check("R7 underflow sticky q1", d, 32'h0000000C);
        idle(2);
        rd(12'h104, d); check("R8 sticky holds", d, 32'h0000000C);
        wr(12'h104, 32'h00000008);
        rd(12'h104, d); check("R8 clear overflow only", d, 32'h00000004);
        wr(12'h104, 32'h00000004);
        rd(12'h104, d); check("R8 clear underflow", d, 32'h0);
        for (int i = 0; i < 3; i++) wr(12'h007, 32'hC000_0000 + 32'(i));
        for (int i = 0; i < 3; i++) begin
            rd(12'h004, d); check("R1 order across wrap", d, 32'hC000_0000 + 32'(i));
        end
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(12'h202, 32'h00200840);
        wr(12'h108, 32'h00000004);
        idle(2);
        check("R9 not-empty idle no irq", {31'd0, irq}, 32'd0);
        wr(12'h008, 32'h1);
        idle(2);
        check("R10 irq on not-empty edge", {31'd0, irq}, 32'd1);
        rd(12'h10A, d); check("R10 pending bit q2", d, 32'h00000004);
        wr(12'h10A, 32'h00000004);
        idle(2);
        check("R10 cleared while level holds", {31'd0, irq}, 32'd0);
        rd(12'h008, d);
        wr(12'h008, 32'h2);
        idle(2);
        check("R10 new edge sets again", {31'd0, irq}, 32'd1);
        wr(12'h108, 32'h0);
        idle(1);
        check("R11 masked by enable", {31'd0, irq}, 32'd0);
        rd(12'h10A, d); check("R11 pending kept while masked", d, 32'h00000004);
        wr(12'h10A, 32'h00000004);
        wr(12'h202, 32'h00000840);
        wr(12'h108, 32'h00000004);
        wr(12'h008, 32'h3);
        idle(2);
        check("R9 empty source quiet when filled", {31'd0, irq}, 32'd0);
        rd(12'h008, d);
        idle(2);
        check("R9 empty source fires on drain", {31'd0, irq}, 32'd1);
        wr(12'h10A, 32'h00000004);
        wr(12'h108, 32'h0);
        idle(1);
        check("R11 irq low at end", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_upper;
        logic [31:0] d;
        wr(12'h0A0, 32'h5);
        idle(1);
        rd(12'h106, d); check("R5 q40 not nearly empty", d, 32'hFFFFFEFF);
        wr(12'h228, 32'h00000500);
        idle(1);
        rd(12'h106, d); check("R2 config write empties q40", d, 32'hFFFFFFFF);
        for (int i = 0; i < 17; i++) wr(12'h0A1, 32'hE000_0000 + 32'(i));
        idle(1);
        rd(12'h107, d); check("R5 q40 full", d, 32'h00000100);
        rd(12'h105, d); check("R6 upper half no sticky", d, 32'h0);
        rd(12'h0A2, d); check("R1 upper queue head", d, 32'hE000_0000);
    endtask

    task automatic t_misc;
        logic [31:0] d;
        rd(12'h180, d); check("R12 unmapped reads zero", d, 32'h0);
        wr(12'h200, 32'h00034000);
        idle(1);
        rd(12'h100, d); check("R2 reconfig empties q0", d, 32'h33334333);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_fifo;
        t_wm;
        t_overflow;
        t_irq;
        t_upper;
        t_misc;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule